// File: doc/BRIEF.md
# Pipeline Hazard Stall Scoreboard

This block sits beside the issue stage of an in-order core and decides how many penalty cycles each issued instruction must absorb. Every valid issue slot presents the instruction's register operands, its class flags and its PC. The block compares these with a short history of which registers recent instructions changed, and answers combinationally with a stall count in the same cycle. It also adds that count to one of seven per-category penalty counters.

History is kept as 32-bit register masks, one per past issue slot, three slots deep. A parallel chain of the same depth records only the registers loaded by block register loads. General registers map to mask bits 0 to 15 and special registers to bits 16 to 31, so a register index selects its own bit. Two special-register slots always read as zero, and their bits are reused as event markers: bit 16 means "a jump issued" and bit 20 means "memory was written". Bit 23 is the multiply-overflow special register. A stall of N cycles ages both chains by N empty slots before the issuing instruction's own entry is pushed. Slots with no valid instruction leave all state alone.

Top module: `hazard_scoreboard`

## Requirements
- R1: Synchronous active-high reset empties both history chains and zeroes all counters. With no valid instruction the stall output is 0.
- R2: A source or destination-input operand that a block register load wrote one, two or three issue slots earlier demands 3, 2 or 1 stall cycles. The block load writes registers 0 up to its last-register field. If both operands hit, the larger demand is taken.
- R3: A memory access whose address register (the source operand) was changed in the previous slot demands 1 stall cycle.
- R4: A memory read demands 2 stall cycles when a memory write issued in either of the two previous slots.
- R5: A jump through a register (the source operand) demands 2 stall cycles if that register changed in the previous slot, and 1 if it changed two slots back.
- R6: A multiply demands 1 stall cycle if its source or destination-input operand changed in the previous slot. A multiply marks bit 23 as changed.
- R7: Directly after a jump, a 16-bit immediate demands 1 stall cycle when PC bits [4:1] are 4'b1111. A 32-bit immediate demands 1 stall cycle when PC bits [4:1] are 4'b1110.
- R8: A block register store of registers 0 up to its last-register field demands 2 stall cycles if any of them changed in the previous slot, and 1 if one changed two slots back.
- R9: A destination write to index 16 or 20 sets no history bit. It can therefore raise neither a false jump marker nor a false memory-write marker.
- R10: The stall output is the largest demand among all categories. Before the instruction's own entry is pushed, the history is aged by one empty slot for each stall cycle.
- R11: Each valid issue adds its stall count to the counter of the category with the largest demand. Ties go to the lowest category index: 0 block load, 1 block store, 2 register jump, 3 read after write, 4 memory address, 5 multiply, 6 immediate after jump. Counter c sits at bits [c*16 +: 16]. Slots without a valid instruction change neither history nor counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instValid | input | 1 | An instruction issues this cycle |
| srcReg | input | 5 | Source operand register index |
| srcValid | input | 1 | Source operand present |
| dstInReg | input | 5 | Destination register read as an operand |
| dstInValid | input | 1 | Destination-input operand present |
| dstOutReg | input | 5 | Register written by the instruction |
| dstOutValid | input | 1 | Destination write present |
| isMem | input | 1 | Memory access addressed by srcReg |
| isMemRead | input | 1 | Memory read |
| isMemWrite | input | 1 | Memory write |
| isJump | input | 1 | Jump or taken branch |
| isJumpReg | input | 1 | Jump target taken from srcReg |
| isMul | input | 1 | Multiply |
| isBlockLoad | input | 1 | Block load into registers 0..blkLast |
| isBlockStore | input | 1 | Block store from registers 0..blkLast |
| isImm16 | input | 1 | Carries a 16-bit immediate |
| isImm32 | input | 1 | Carries a 32-bit immediate |
| blkLast | input | 4 | Highest register of a block transfer |
| pc | input | 32 | PC of the instruction |
| stallCycles | output | 2 | Penalty cycles for this instruction |
| penaltyCnt | output | 112 | Seven 16-bit per-category penalty counters |

## Verification
The two functions that can fall into the same slot are two hazard categories raised by a single instruction. Examples are a memory access whose address register was just written while its other operand comes from a block load two slots back, and a multiply hazard that meets an immediate-after-jump hazard. The bench builds both cases on purpose. It expects the stall to be the larger demand and not the sum. It expects the whole stall to go to the single winning counter chosen by the tie order. It then checks that the aged history gives a zero stall to the instruction that follows.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  localparam int NREGS      = 32;
  localparam int REG_IDX_W  = $clog2(NREGS);
  localparam int HIST_DEPTH = 3;
  localparam int STALL_W    = $clog2(HIST_DEPTH + 1);
  localparam int NCAT       = 7;
  localparam int LIM_W      = 4;
  localparam int PC_W       = 32;

  typedef logic [NREGS-1:0] regMask_t;

  typedef struct packed {
    logic                 valid;
    logic [REG_IDX_W-1:0] src;
    logic                 srcValid;
    logic [REG_IDX_W-1:0] dstIn;
    logic                 dstInValid;
    logic [REG_IDX_W-1:0] dstOut;
    logic                 dstOutValid;
    logic                 isMem;
    logic                 isMemRead;
    logic                 isMemWrite;
    logic                 isJump;
    logic                 isJumpReg;
    logic                 isMul;
    logic                 isBlockLoad;
    logic                 isBlockStore;
    logic                 isImm16;
    logic                 isImm32;
    logic [LIM_W-1:0]     blkLast;
    logic [PC_W-1:0]      pc;
  } instr_t;

  typedef struct packed {
    logic               issue;
    logic [STALL_W-1:0] stall;
    logic [NCAT-1:0]    win;
  } ctrlStrobe_t;

  function automatic regMask_t lowMask(input logic [LIM_W-1:0] last);
    regMask_t m;
    for (int i = 0; i < NREGS; i++) m[i] = (i <= int'(last));
    return m;
  endfunction
endpackage

// File: rtl/hzd_ctrl.sv
module hzd_ctrl
  import hzd_pkg::*;
#(
  parameter int JUMP_BIT  = 16,
  parameter int WRITE_BIT = 20
) (
  input  logic                         clk,
  input  logic                         rst,
  input  instr_t                       instr,
  input  regMask_t [HIST_DEPTH-1:0]    hist,
  input  regMask_t [HIST_DEPTH-1:0]    blkHist,
  output ctrlStrobe_t                  strb
);
  logic [NCAT-1:0][STALL_W-1:0] demand;
  logic [STALL_W-1:0]           best;
  logic [NCAT-1:0]              winVec;
  regMask_t                     blkMask;

  function automatic logic [STALL_W-1:0] loadDist(input regMask_t [HIST_DEPTH-1:0] bh,
                                                  input logic [REG_IDX_W-1:0] idx);
    logic [STALL_W-1:0] d;
    d = '0;
    for (int k = HIST_DEPTH - 1; k >= 0; k--)
      if (bh[k][idx]) d = STALL_W'(HIST_DEPTH - k);
    return d;
  endfunction

  always_comb begin
    logic [STALL_W-1:0] dSrc, dDst;
    blkMask = lowMask(instr.blkLast);
    demand  = '0;
    dSrc    = instr.srcValid   ? loadDist(blkHist, instr.src)   : '0;
    dDst    = instr.dstInValid ? loadDist(blkHist, instr.dstIn) : '0;
    if (instr.valid) begin
      demand[0] = (dSrc > dDst) ? dSrc : dDst;
      if (instr.isBlockStore)
        demand[1] = |(hist[0] & blkMask) ? STALL_W'(2) :
                    |(hist[1] & blkMask) ? STALL_W'(1) : '0;
      if (instr.isJumpReg)
        demand[2] = hist[0][instr.src] ? STALL_W'(2) :
                    hist[1][instr.src] ? STALL_W'(1) : '0;
      if (instr.isMemRead && (hist[0][WRITE_BIT] || hist[1][WRITE_BIT]))
        demand[3] = STALL_W'(2);
      if (instr.isMem && hist[0][instr.src])
        demand[4] = STALL_W'(1);
      if (instr.isMul && (hist[0][instr.src] || hist[0][instr.dstIn]))
        demand[5] = STALL_W'(1);
      if (hist[0][JUMP_BIT] &&
          ((instr.isImm16 && instr.pc[4:1] == 4'b1111) ||
           (instr.isImm32 && instr.pc[4:1] == 4'b1110)))
        demand[6] = STALL_W'(1);
    end
  end

  always_comb begin
    int winIdx;
    best   = '0;
    winIdx = 0;
    for (int c = 0; c < NCAT; c++)
      if (demand[c] > best) begin
        best   = demand[c];
        winIdx = c;
      end
    winVec = '0;
    if (best != '0) winVec[winIdx] = 1'b1;
  end

  assign strb.issue = instr.valid;
  assign strb.stall = best;
  assign strb.win   = winVec;

  AST_WIN_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    (strb.stall != '0) |-> $onehot(strb.win)) else $error("win not onehot"); // R11
  AST_IDLE_NO_STALL: assert property (@(posedge clk) disable iff (rst)
    !instr.valid |-> (strb.stall == '0)) else $error("stall while idle"); // R1
endmodule

// File: rtl/hzd_dp.sv
module hzd_dp
  import hzd_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int JUMP_BIT  = 16,
  parameter int WRITE_BIT = 20,
  parameter int MOF_BIT   = 23
) (
  input  logic                       clk,
  input  logic                       rst,
  input  instr_t                     instr,
  input  ctrlStrobe_t                strb,
  output regMask_t [HIST_DEPTH-1:0]  hist,
  output regMask_t [HIST_DEPTH-1:0]  blkHist,
  output logic [NCAT*CNT_W-1:0]      cntFlat
);
  regMask_t                  newMask, newBlk;
  regMask_t [HIST_DEPTH-1:0] histNext, blkNext;

  always_comb begin
    newMask = '0;
    if (instr.dstOutValid && int'(instr.dstOut) != JUMP_BIT && int'(instr.dstOut) != WRITE_BIT)
      newMask[instr.dstOut] = 1'b1;
    if (instr.isJump)     newMask[JUMP_BIT]  = 1'b1;
    if (instr.isMemWrite) newMask[WRITE_BIT] = 1'b1;
    if (instr.isMul)      newMask[MOF_BIT]   = 1'b1;
    newBlk = instr.isBlockLoad ? lowMask(instr.blkLast) : '0;
    if (instr.isBlockLoad) newMask = newMask | newBlk;
  end

  always_comb begin
    histNext[0] = newMask;
    blkNext[0]  = newBlk;
    for (int k = 1; k < HIST_DEPTH; k++) begin
      int from;
      from = k - 1 - int'(strb.stall);
      histNext[k] = (from >= 0) ? hist[from]    : '0;
      blkNext[k]  = (from >= 0) ? blkHist[from] : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hist    <= '0;
      blkHist <= '0;
    end else if (strb.issue) begin
      hist    <= histNext;
      blkHist <= blkNext;
    end
  end

  for (genvar c = 0; c < NCAT; c++) begin : g_cnt
    logic [CNT_W-1:0] cnt;
    always_ff @(posedge clk) begin
      if (rst) cnt <= '0;
      else if (strb.issue && strb.win[c]) cnt <= cnt + CNT_W'(strb.stall);
    end
    assign cntFlat[c*CNT_W +: CNT_W] = cnt;
  end

  AST_JUMP_MARK: assert property (@(posedge clk) disable iff (rst)
    (strb.issue && instr.isJump) |=> hist[0][JUMP_BIT]) else $error("jump marker"); // R7
  AST_ZERO_SLOT: assert property (@(posedge clk) disable iff (rst)
    (strb.issue && instr.dstOutValid && int'(instr.dstOut) == WRITE_BIT && !instr.isMemWrite)
    |=> !hist[0][WRITE_BIT]) else $error("false write marker"); // R9
  AST_MUL_MOF: assert property (@(posedge clk) disable iff (rst)
    (strb.issue && instr.isMul) |=> hist[0][MOF_BIT]) else $error("mof mark"); // R6
  AST_AGE_ON_STALL: assert property (@(posedge clk) disable iff (rst)
    (strb.issue && strb.stall != '0) |=> (hist[1] == '0 && blkHist[1] == '0)) else $error("aging"); // R10
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !strb.issue |=> ($stable(hist) && $stable(cntFlat))) else $error("idle change"); // R11
endmodule

// File: rtl/hazard_scoreboard.sv
module hazard_scoreboard
  import hzd_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int JUMP_BIT  = 16,
  parameter int WRITE_BIT = 20,
  parameter int MOF_BIT   = 23
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    instValid,
  input  logic [REG_IDX_W-1:0]    srcReg,
  input  logic                    srcValid,
  input  logic [REG_IDX_W-1:0]    dstInReg,
  input  logic                    dstInValid,
  input  logic [REG_IDX_W-1:0]    dstOutReg,
  input  logic                    dstOutValid,
  input  logic                    isMem,
  input  logic                    isMemRead,
  input  logic                    isMemWrite,
  input  logic                    isJump,
  input  logic                    isJumpReg,
  input  logic                    isMul,
  input  logic                    isBlockLoad,
  input  logic                    isBlockStore,
  input  logic                    isImm16,
  input  logic                    isImm32,
  input  logic [LIM_W-1:0]        blkLast,
  input  logic [PC_W-1:0]         pc,
  output logic [STALL_W-1:0]      stallCycles,
  output logic [NCAT*CNT_W-1:0]   penaltyCnt
);
  instr_t                    instr;
  ctrlStrobe_t               strb;
  regMask_t [HIST_DEPTH-1:0] hist, blkHist;

  assign instr = '{valid: instValid, src: srcReg, srcValid: srcValid,
                   dstIn: dstInReg, dstInValid: dstInValid,
                   dstOut: dstOutReg, dstOutValid: dstOutValid,
                   isMem: isMem, isMemRead: isMemRead, isMemWrite: isMemWrite,
                   isJump: isJump, isJumpReg: isJumpReg, isMul: isMul,
                   isBlockLoad: isBlockLoad, isBlockStore: isBlockStore,
                   isImm16: isImm16, isImm32: isImm32, blkLast: blkLast, pc: pc};

  hzd_ctrl #(.JUMP_BIT(JUMP_BIT), .WRITE_BIT(WRITE_BIT)) u_ctrl (
    .clk(clk), .rst(rst), .instr(instr), .hist(hist), .blkHist(blkHist), .strb(strb));

  hzd_dp #(.CNT_W(CNT_W), .JUMP_BIT(JUMP_BIT), .WRITE_BIT(WRITE_BIT), .MOF_BIT(MOF_BIT)) u_dp (
    .clk(clk), .rst(rst), .instr(instr), .strb(strb),
    .hist(hist), .blkHist(blkHist), .cntFlat(penaltyCnt));

  assign stallCycles = strb.stall;
endmodule

// File: tb/hazard_scoreboard_tb.sv
`timescale 1ns/100ps
module hazard_scoreboard_tb;
  localparam int CW = 16;
  localparam int F_MEM = 1, F_RD = 2, F_WR = 4, F_JMP = 8, F_JR = 16, F_MUL = 32,
                 F_BL = 64, F_BS = 128, F_I16 = 256, F_I32 = 512;

  logic clk = 0, rst = 1, instValid = 0;
  logic [4:0] srcReg = 0, dstInReg = 0, dstOutReg = 0;
  logic srcValid = 0, dstInValid = 0, dstOutValid = 0;
  logic isMem = 0, isMemRead = 0, isMemWrite = 0, isJump = 0, isJumpReg = 0, isMul = 0;
  logic isBlockLoad = 0, isBlockStore = 0, isImm16 = 0, isImm32 = 0;
  logic [3:0] blkLast = 0;
  logic [31:0] pc = 0;
  logic [1:0] stallCycles;
  logic [7*CW-1:0] penaltyCnt;

  int nChecks = 0, nFails = 0;
  int expCnt[7];
  int qStall[$];
  string qReq[$];

  always #2.5 clk = ~clk;

  hazard_scoreboard u_dut (.*);

  task automatic check(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // driver: applies one instruction at a falling edge and queues its expected stall
  task automatic issue(int src, int sv, int din, int dinv, int dout, int doutv,
                       int flags, int lim, int pcv, int expStall, int expCat, string req);
    @(negedge clk);
    instValid = 1;
    srcReg = 5'(src); srcValid = sv[0]; dstInReg = 5'(din); dstInValid = dinv[0];
    dstOutReg = 5'(dout); dstOutValid = doutv[0];
    isMem = (flags & F_MEM) != 0; isMemRead = (flags & F_RD) != 0;
    isMemWrite = (flags & F_WR) != 0; isJump = (flags & F_JMP) != 0;
    isJumpReg = (flags & F_JR) != 0; isMul = (flags & F_MUL) != 0;
    isBlockLoad = (flags & F_BL) != 0; isBlockStore = (flags & F_BS) != 0;
    isImm16 = (flags & F_I16) != 0; isImm32 = (flags & F_I32) != 0;
    blkLast = 4'(lim); pc = 32'(pcv);
    qStall.push_back(expStall);
    qReq.push_back(req);
    if (expCat >= 0) expCnt[expCat] += expStall;
  endtask

  task automatic nop();
    issue(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, -1, "R10 nop");
  endtask

  task automatic dst(int r);
    issue(0, 0, 0, 0, r, 1, 0, 0, 0, 0, -1, "R10 writer");
  endtask

  task automatic idle();
    @(negedge clk);
    instValid = 0;
  endtask

  task automatic checkCounters(string req);
    idle();
    @(negedge clk); #1;
    for (int c = 0; c < 7; c++)
      check(req, int'(penaltyCnt[c*CW +: CW]), expCnt[c]);
  endtask

  task automatic doReset();
    @(negedge clk);
    instValid = 0; rst = 1;
    @(negedge clk);
    rst = 0;
    for (int c = 0; c < 7; c++) expCnt[c] = 0;
  endtask

  // monitor: compares the combinational stall of each issued instruction
  initial begin
    forever begin
      @(negedge clk); #1;
      if (instValid && qStall.size() > 0) begin
        int e;
        string r;
        e = qStall.pop_front();
        r = qReq.pop_front();
        check(r, int'(stallCycles), e);
      end
    end
  end

  initial begin
    #(200000 * 5);
    nFails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    doReset();
    #1;
    check("R1 idle stall", int'(stallCycles), 0);
    for (int c = 0; c < 7; c++) check("R1 counter", int'(penaltyCnt[c*CW +: CW]), 0);

    // R2 block load distances
    issue(0, 0, 0, 0, 0, 0, F_BL, 3, 0, 0, -1, "R2 load");
    issue(2, 1, 0, 0, 0, 0, 0, 0, 0, 3, 0, "R2 dist1");
    issue(2, 1, 0, 0, 0, 0, 0, 0, 0, 0, -1, "R10 aged after 3");
    issue(0, 0, 0, 0, 0, 0, F_BL, 1, 0, 0, -1, "R2 load");
    nop(); nop();
    issue(1, 1, 0, 0, 0, 0, 0, 0, 0, 1, 0, "R2 dist3");
    issue(0, 0, 0, 0, 0, 0, F_BL, 0, 0, 0, -1, "R2 load");
    nop();
    issue(0, 0, 0, 1, 0, 0, 0, 0, 0, 2, 0, "R2 dstIn dist2");
    // overlap: block load demand 2 vs memory address demand 1
    issue(0, 0, 0, 0, 0, 0, F_BL, 2, 0, 0, -1, "R2 load");
    dst(5);
    issue(5, 1, 1, 1, 0, 0, F_MEM, 0, 0, 2, 0, "R10 max merge");
    nop();
    checkCounters("R11 counts A");

    doReset();
    // R3 memory address
    dst(7);
    issue(7, 1, 0, 0, 0, 0, F_MEM, 0, 0, 1, 4, "R3 addr hazard");
    issue(7, 1, 0, 0, 0, 0, F_MEM, 0, 0, 0, -1, "R3 no hazard");
    // R4 read after write
    issue(0, 0, 0, 0, 0, 0, F_WR, 0, 0, 0, -1, "R4 write");
    nop();
    issue(0, 0, 0, 0, 0, 0, F_RD, 0, 0, 2, 3, "R4 read 2 back");
    issue(0, 0, 0, 0, 0, 0, F_WR, 0, 0, 0, -1, "R4 write");
    issue(0, 0, 0, 0, 0, 0, F_RD, 0, 0, 2, 3, "R4 read 1 back");
    issue(0, 0, 0, 0, 0, 0, F_WR, 0, 0, 0, -1, "R4 write");
    nop(); nop();
    issue(0, 0, 0, 0, 0, 0, F_RD, 0, 0, 0, -1, "R4 read 3 back");
    // R5 register jump
    dst(9);
    issue(9, 1, 0, 0, 0, 0, F_JR | F_JMP, 0, 0, 2, 2, "R5 dist1");
    dst(9);
    nop();
    issue(9, 1, 0, 0, 0, 0, F_JR, 0, 0, 1, 2, "R5 dist2");
    // R11 idle slots do not age history
    dst(9);
    idle(); idle(); idle();
    issue(9, 1, 0, 0, 0, 0, F_JR, 0, 0, 2, 2, "R11 idle no aging");
    checkCounters("R11 counts B");

    doReset();
    // R6 multiply, then jump through the overflow register
    dst(4);
    issue(3, 1, 4, 1, 4, 1, F_MUL, 0, 0, 1, 5, "R6 mul operand");
    issue(23, 1, 0, 0, 0, 0, F_JR, 0, 0, 2, 2, "R6 mof marked");
    // R7 immediates after jump
    issue(0, 0, 0, 0, 0, 0, F_JMP, 0, 0, 0, -1, "R7 jump");
    issue(0, 0, 0, 0, 0, 0, F_I16, 0, 'h1E, 1, 6, "R7 imm16 hit");
    issue(0, 0, 0, 0, 0, 0, F_JMP, 0, 0, 0, -1, "R7 jump");
    issue(0, 0, 0, 0, 0, 0, F_I16, 0, 'h1C, 0, -1, "R7 imm16 miss");
    issue(0, 0, 0, 0, 0, 0, F_JMP, 0, 0, 0, -1, "R7 jump");
    issue(0, 0, 0, 0, 0, 0, F_I32, 0, 'h3C, 1, 6, "R7 imm32 hit");
    issue(0, 0, 0, 0, 0, 0, F_I32, 0, 'h1C, 0, -1, "R7 imm32 no jump");
    // R8 block store
    dst(2);
    issue(0, 0, 0, 0, 0, 0, F_BS, 3, 0, 2, 1, "R8 dist1");
    dst(6);
    nop();
    issue(0, 0, 0, 0, 0, 0, F_BS, 3, 0, 0, -1, "R8 outside range");
    dst(1);
    nop();
    issue(0, 0, 0, 0, 0, 0, F_BS, 1, 0, 1, 1, "R8 dist2");
    checkCounters("R11 counts C");

    doReset();
    // R9 zero-slot writes leave no markers
    dst(16);
    issue(0, 0, 0, 0, 0, 0, F_I16, 0, 'h1E, 0, -1, "R9 no jump marker");
    dst(20);
    issue(0, 0, 0, 0, 0, 0, F_RD, 0, 0, 0, -1, "R9 no write marker");
    dst(20);
    issue(20, 1, 0, 0, 0, 0, F_JR, 0, 0, 0, -1, "R9 slot 20 untracked");
    // R11 tie between multiply and immediate: multiply wins
    issue(0, 0, 0, 0, 3, 1, F_JMP, 0, 0, 0, -1, "R11 setup");
    issue(3, 1, 0, 1, 0, 0, F_MUL | F_I16, 0, 'h1E, 1, 5, "R11 tie to mul");
    issue(3, 1, 0, 1, 0, 0, F_MUL | F_I16, 0, 'h1E, 0, -1, "R10 after tie");
    checkCounters("R11 counts D");

    doReset();
    #1;
    for (int c = 0; c < 7; c++) check("R1 counter after reset", int'(penaltyCnt[c*CW +: CW]), 0);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule